// File: doc/BRIEF.md
# AES-128 Round-Key Precompute Engine

This block turns a 128-bit AES cipher key into the full set of round keys and keeps them in an internal two-port word memory. The key arrives as four 32-bit column writes. Writing the last column starts the forward schedule, which produces one new 32-bit word per clock. Counting the four load cycles, all 44 words are in place after 44 cycles. A cipher datapath can then fetch any word by round number and column for encryption.

To decrypt with the equivalent inverse cipher, the datapath raises a request once the forward keys are ready. A second pass then reads the forward words back through the memory's other port. Each middle-round key is passed through InvMixColumns, and the result is stored in a separate region in reverse round order. The pass always takes 48 cycles, so a fresh key is ready for decryption after 92 cycles in the worst case. The same read port serves both regions, chosen by a mode bit.

Top module: `aes_key_expander`

## Requirements
- R1: After reset, both `fwd_ready` and `dec_ready` are low.
- R2: Column write c (0..3) stores `key_word` as word c of round key 0. Column 0 is the most significant word of the cipher key, and byte 0 of a word sits in bits 31:24.
- R3: For 4 ≤ i < 44, word i equals word i−4 XOR t, where t is word i−1. When i is a multiple of 4, t is instead S-box applied bytewise to word i−1 rotated left by one byte, XOR a round constant in bits 31:24. That constant starts at 0x01 for round 1 and doubles in GF(2^8) (modulus 0x11B) for each later round.
- R4: `fwd_ready` rises exactly 40 clock edges after the edge that accepts the column-3 write. With back-to-back loads, this is 44 cycles from the first word.
- R5: `inv_req` is accepted only when `fwd_ready` is high, `dec_ready` is low and no pass is running. `dec_ready` rises exactly 48 edges after the accepting edge, and `dec_ready` is never high while `fwd_ready` is low.
- R6: Decryption key 0 equals forward round key 10, and decryption key 10 equals forward round key 0, column by column.
- R7: Decryption key r, for 1 ≤ r ≤ 9, equals InvMixColumns applied to each column of forward round key 10−r.
- R8: A read presents `rd_round`, `rd_col` and `rd_dec` (0 selects forward keys, 1 selects decryption keys). The addressed word appears on `rd_data` after the next clock edge.
- R9: Any column write clears both ready flags at the edge that accepts it and aborts any pass in progress.
- R10: `inv_req` while `fwd_ready` is low has no effect: `dec_ready` stays low.
- R11: The forward round keys remain readable and unchanged after the decryption pass completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_wr | input | 1 | Write one cipher-key column |
| key_col | input | 2 | Column index of the key write |
| key_word | input | 32 | Key column data |
| inv_req | input | 1 | Request derivation of decryption keys |
| rd_round | input | 4 | Round index to read (0..10) |
| rd_col | input | 2 | Column index to read |
| rd_dec | input | 1 | Region select: 0 forward, 1 decryption |
| rd_data | output | 32 | Word read, valid one cycle after the address |
| fwd_ready | output | 1 | Forward round keys valid |
| dec_ready | output | 1 | Decryption round keys valid |

## Verification
Three keys drive the schedule. The first is the standard test key, whose round-1 and round-10 words are checked against known constants. The second is an ascending byte key with a second known round-10 word. The third is an all-ones key that exercises every S-box input at 0xFF and the reduction of the round constant past 0x80. Every word of both regions is compared against a bench model, so a rotation in the wrong direction, a missing round constant or InvMixColumns applied to the end rounds shows up in specific words. The ready timing is measured in edges. A partial key load followed by a request shows that an early request is ignored.

// File: rtl/aes_kx_pkg.sv
package aes_kx_pkg;

   typedef enum logic [1:0] {KX_IDLE, KX_FWD, KX_INV} kx_state_e;

   // GF(2^8) product, modulus x^8+x^4+x^3+x+1
   function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
      logic [7:0] acc;
      logic [7:0] sh;
      acc = 8'h00;
      sh  = a;
      for (int k = 0; k < 8; k++) begin
         if (b[k]) acc = acc ^ sh;
         sh = {sh[6:0], 1'b0} ^ (sh[7] ? 8'h1b : 8'h00);
      end
      return acc;
   endfunction

   // forward S-box: x^254 (inverse, 0 -> 0) then affine map
   function automatic logic [7:0] sbox_byte(input logic [7:0] x);
      logic [7:0] sq;
      logic [7:0] inv;
      logic [7:0] y;
      sq  = x;
      inv = 8'h01;
      for (int k = 1; k < 8; k++) begin
         sq  = gf_mul(sq, sq);
         inv = gf_mul(inv, sq);
      end
      y = inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]}
              ^ {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
      return y;
   endfunction

   // InvMixColumns on one column, byte 0 in bits 31:24
   function automatic logic [31:0] inv_mix_col(input logic [31:0] c);
      logic [7:0] a0, a1, a2, a3;
      a0 = c[31:24]; a1 = c[23:16]; a2 = c[15:8]; a3 = c[7:0];
      return {gf_mul(a0,8'h0e) ^ gf_mul(a1,8'h0b) ^ gf_mul(a2,8'h0d) ^ gf_mul(a3,8'h09),
              gf_mul(a0,8'h09) ^ gf_mul(a1,8'h0e) ^ gf_mul(a2,8'h0b) ^ gf_mul(a3,8'h0d),
              gf_mul(a0,8'h0d) ^ gf_mul(a1,8'h09) ^ gf_mul(a2,8'h0e) ^ gf_mul(a3,8'h0b),
              gf_mul(a0,8'h0b) ^ gf_mul(a1,8'h0d) ^ gf_mul(a2,8'h09) ^ gf_mul(a3,8'h0e)};
   endfunction

endpackage

// File: rtl/kx_sub_word.sv
module kx_sub_word #(
   parameter int LANES = 4
) (
   input  logic [8*LANES-1:0] din,
   output logic [8*LANES-1:0] dout
);
   import aes_kx_pkg::*;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign dout[8*g +: 8] = sbox_byte(din[8*g +: 8]);
   end

endmodule

// File: rtl/kx_inv_mix.sv
module kx_inv_mix (
   input  logic [31:0] din,
   output logic [31:0] dout
);
   import aes_kx_pkg::*;

   assign dout = inv_mix_col(din);

endmodule

// File: rtl/kx_key_ram.sv
module kx_key_ram #(
   parameter int DW    = 32,
   parameter int DEPTH = 88,
   parameter int AW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          a_we,
   input  logic [AW-1:0] a_addr,
   input  logic [DW-1:0] a_din,
   input  logic [AW-1:0] b_addr,
   output logic [DW-1:0] b_q
);
   logic [DW-1:0] mem [DEPTH];

   initial begin
      assert (DEPTH <= (1 << AW)) else $error("kx_key_ram: address too narrow");
   end

   always_ff @(posedge clk) begin
      if (a_we) mem[a_addr] <= a_din;
      b_q <= mem[b_addr];
   end

endmodule

// File: rtl/aes_key_expander.sv
module aes_key_expander #(
   parameter int NR    = 10,
   parameter int RND_W = $clog2(NR + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             key_wr,
   input  logic [1:0]       key_col,
   input  logic [31:0]      key_word,
   input  logic             inv_req,
   input  logic [RND_W-1:0] rd_round,
   input  logic [1:0]       rd_col,
   input  logic             rd_dec,
   output logic [31:0]      rd_data,
   output logic             fwd_ready,
   output logic             dec_ready
);
   import aes_kx_pkg::*;

   localparam int KW      = 4;
   localparam int NW      = KW * (NR + 1);
   localparam int DEPTH   = 2 * NW;
   localparam int AW      = $clog2(DEPTH);
   localparam int INV_CYC = NW + 4;
   localparam int CW      = $clog2(INV_CYC + 1);
   localparam logic [CW-1:0] CNT_FWD_FIRST = CW'(KW);
   localparam logic [CW-1:0] CNT_FWD_LAST  = CW'(NW - 1);
   localparam logic [CW-1:0] CNT_RD_END    = CW'(NW);
   localparam logic [CW-1:0] CNT_INV_LAST  = CW'(INV_CYC - 1);

   initial begin
      assert (NR >= 1 && NR <= 14) else $error("aes_key_expander: NR out of range");
      assert ((1 << RND_W) >= NR + 1) else $error("aes_key_expander: RND_W too narrow");
   end

   kx_state_e     state;
   logic [CW-1:0] cnt;
   logic [31:0]   win [KW];
   logic [7:0]    rcon;
   logic          p1_v, p2_v;
   logic [CW-1:0] p1_j, p2_j;
   logic [31:0]   p2_word;

   // forward next-word logic
   logic [31:0] rot_w, sub_rot, temp_w, new_word;
   logic        round_edge;

   assign rot_w      = {win[KW-1][23:0], win[KW-1][31:24]};
   assign round_edge = (cnt[1:0] == 2'b00);

   kx_sub_word #(.LANES(4)) u_sub (.din(rot_w), .dout(sub_rot));

   assign temp_w   = round_edge ? (sub_rot ^ {rcon, 24'h000000}) : win[KW-1];
   assign new_word = win[0] ^ temp_w;

   // memory ports
   logic          a_we;
   logic [AW-1:0] a_addr, b_addr;
   logic [31:0]   a_din, mem_q, imc_q, xform_w;

   always_comb begin
      a_we   = 1'b0;
      a_addr = '0;
      a_din  = '0;
      if (key_wr) begin
         a_we   = 1'b1;
         a_addr = AW'(key_col);
         a_din  = key_word;
      end else if (state == KX_FWD) begin
         a_we   = 1'b1;
         a_addr = AW'(cnt);
         a_din  = new_word;
      end else if (p2_v) begin
         a_we   = 1'b1;
         a_addr = AW'(NW + int'(p2_j));
         a_din  = p2_word;
      end
   end

   always_comb begin
      if (state == KX_INV && cnt < CNT_RD_END)
         b_addr = AW'((NR - int'(cnt[CW-1:2])) * KW + int'(cnt[1:0]));
      else
         b_addr = AW'((rd_dec ? NW : 0) + int'(rd_round) * KW + int'(rd_col));
   end

   kx_key_ram #(.DW(32), .DEPTH(DEPTH), .AW(AW)) u_ram (
      .clk    (clk),
      .a_we   (a_we),
      .a_addr (a_addr),
      .a_din  (a_din),
      .b_addr (b_addr),
      .b_q    (mem_q)
   );

   kx_inv_mix u_imc (.din(mem_q), .dout(imc_q));

   // end rounds pass straight through
   assign xform_w = (int'(p1_j) < KW || int'(p1_j) >= NW - KW) ? mem_q : imc_q;
   assign rd_data = mem_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= KX_IDLE;
         cnt       <= '0;
         rcon      <= 8'h01;
         fwd_ready <= 1'b0;
         dec_ready <= 1'b0;
         p1_v      <= 1'b0;
         p1_j      <= '0;
         p2_v      <= 1'b0;
         p2_j      <= '0;
         p2_word   <= '0;
         for (int k = 0; k < KW; k++) win[k] <= '0;
      end else begin
         p1_v    <= 1'b0;
         p2_v    <= p1_v;
         p2_j    <= p1_j;
         p2_word <= xform_w;
         if (key_wr) begin
            fwd_ready    <= 1'b0;
            dec_ready    <= 1'b0;
            p2_v         <= 1'b0;
            rcon         <= 8'h01;
            win[key_col] <= key_word;
            if (key_col == 2'd3) begin
               state <= KX_FWD;
               cnt   <= CNT_FWD_FIRST;
            end else begin
               state <= KX_IDLE;
            end
         end else begin
            case (state)
               KX_FWD: begin
                  for (int k = 0; k < KW - 1; k++) win[k] <= win[k+1];
                  win[KW-1] <= new_word;
                  if (round_edge) rcon <= gf_mul(rcon, 8'h02);
                  if (cnt == CNT_FWD_LAST) begin
                     state     <= KX_IDLE;
                     fwd_ready <= 1'b1;
                     cnt       <= '0;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               KX_INV: begin
                  if (cnt < CNT_RD_END) begin
                     p1_v <= 1'b1;
                     p1_j <= cnt;
                  end
                  if (cnt == CNT_INV_LAST) begin
                     state     <= KX_IDLE;
                     dec_ready <= 1'b1;
                     cnt       <= '0;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               default: begin
                  if (inv_req && fwd_ready && !dec_ready) begin
                     state <= KX_INV;
                     cnt   <= '0;
                  end
               end
            endcase
         end
      end
   end

   assert_flags_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      key_wr |=> (!fwd_ready && !dec_ready));

   assert_dec_needs_fwd_R5: assert property (@(posedge clk) disable iff (!rst_n)
      dec_ready |-> fwd_ready);

   assert_dec_after_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dec_ready) |-> $past(state) == KX_INV);

   assert_early_req_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_req && !fwd_ready && !key_wr) |=> !dec_ready);

   assert_fwd_after_sched_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fwd_ready) |-> $past(state) == KX_FWD);

endmodule

// File: tb/aes_key_expander_bench.sv
module aes_key_expander_bench;

   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        key_wr = 1'b0;
   logic [1:0]  key_col = '0;
   logic [31:0] key_word = '0;
   logic        inv_req = 1'b0;
   logic [3:0]  rd_round = '0;
   logic [1:0]  rd_col = '0;
   logic        rd_dec = 1'b0;
   logic [31:0] rd_data;
   logic        fwd_ready, dec_ready;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   logic [31:0] exp_w [44];
   logic [31:0] inv_w [44];

   always #(CLK_P/2) clk = ~clk;

   aes_key_expander u_aes_key_expander (
      .clk(clk), .rst_n(rst_n), .key_wr(key_wr), .key_col(key_col),
      .key_word(key_word), .inv_req(inv_req), .rd_round(rd_round),
      .rd_col(rd_col), .rd_dec(rd_dec), .rd_data(rd_data),
      .fwd_ready(fwd_ready), .dec_ready(dec_ready));

   // ---------- reference model ----------
   function automatic logic [7:0] m_mul(input logic [7:0] a, input logic [7:0] b);
      logic [7:0] r = 0, x = a, y = b;
      while (y != 0) begin
         if (y[0]) r ^= x;
         x = x[7] ? ((x << 1) ^ 8'h1b) : (x << 1);
         y = y >> 1;
      end
      return r;
   endfunction

   function automatic logic [7:0] m_sbox(input logic [7:0] x);
      logic [7:0] inv = 0;
      logic [7:0] s;
      for (int y = 1; y < 256; y++) if (m_mul(x, 8'(y)) == 8'h01) inv = 8'(y);
      s = 8'h63;
      for (int bt = 0; bt < 8; bt++)
         s[bt] = s[bt] ^ inv[bt] ^ inv[(bt+4)%8] ^ inv[(bt+5)%8] ^ inv[(bt+6)%8] ^ inv[(bt+7)%8];
      return s;
   endfunction

   function automatic logic [31:0] m_imc(input logic [31:0] c);
      logic [7:0] a [4];
      logic [7:0] k [4];
      logic [31:0] o = 0;
      k[0] = 8'h0e; k[1] = 8'h0b; k[2] = 8'h0d; k[3] = 8'h09;
      for (int i = 0; i < 4; i++) a[i] = c[31-8*i -: 8];
      for (int row = 0; row < 4; row++) begin
         logic [7:0] v = 0;
         for (int i = 0; i < 4; i++) v ^= m_mul(a[i], k[(i - row + 4) % 4]);
         o[31-8*row -: 8] = v;
      end
      return o;
   endfunction

   task automatic build_model(input logic [127:0] key);
      logic [7:0] rc = 8'h01;
      for (int i = 0; i < 4; i++) exp_w[i] = key[127-32*i -: 32];
      for (int i = 4; i < 44; i++) begin
         logic [31:0] t = exp_w[i-1];
         if (i % 4 == 0) begin
            t = {t[23:0], t[31:24]};
            t = {m_sbox(t[31:24]), m_sbox(t[23:16]), m_sbox(t[15:8]), m_sbox(t[7:0])};
            t[31:24] ^= rc;
            rc = m_mul(rc, 8'h02);
         end
         exp_w[i] = exp_w[i-4] ^ t;
      end
      for (int r = 0; r <= 10; r++)
         for (int c = 0; c < 4; c++)
            inv_w[r*4+c] = (r == 0 || r == 10) ? exp_w[(10-r)*4+c] : m_imc(exp_w[(10-r)*4+c]);
   endtask

   // ---------- helpers ----------
   task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv, input string what);
      n_chk++;
      if (act !== expv) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
      end
   endtask

   task automatic write_col(input int c, input logic [31:0] w);
      @(negedge clk);
      key_wr = 1'b1; key_col = 2'(c); key_word = w;
      @(posedge clk);
      @(negedge clk);
      key_wr = 1'b0;
   endtask

   // back-to-back load; returns edges from column-3 acceptance to fwd_ready
   task automatic load_key(input logic [127:0] key, output int edges);
      for (int c = 0; c < 4; c++) begin
         @(negedge clk);
         key_wr = 1'b1; key_col = 2'(c); key_word = key[127-32*c -: 32];
         @(posedge clk);
         if (c == 0) begin
            @(negedge clk);
            check("R9", {30'd0, fwd_ready, dec_ready}, 32'd0, "flags after first column write");
         end
      end
      @(negedge clk);
      key_wr = 1'b0;
      edges = 0;
      while (!fwd_ready && edges < 200) begin
         @(posedge clk); edges++; @(negedge clk);
      end
      edges = edges + 1 - 1;
   endtask

   task automatic read_word(input bit dec, input int r, input int c, output logic [31:0] d);
      @(negedge clk);
      rd_dec = dec; rd_round = 4'(r); rd_col = 2'(c);
      @(posedge clk);
      @(negedge clk);
      d = rd_data;
   endtask

   task automatic run_inv(output int edges);
      @(negedge clk);
      inv_req = 1'b1;
      @(posedge clk);
      @(negedge clk);
      inv_req = 1'b0;
      edges = 0;
      while (!dec_ready && edges < 200) begin
         @(posedge clk); edges++; @(negedge clk);
      end
   endtask

   task automatic check_fwd_region(input string req);
      logic [31:0] d;
      for (int i = 0; i < 44; i++) begin
         read_word(1'b0, i / 4, i % 4, d);
         check(i < 4 ? "R2" : req, d, exp_w[i], $sformatf("forward word %0d", i));
      end
   endtask

   task automatic check_inv_region();
      logic [31:0] d;
      for (int i = 0; i < 44; i++) begin
         read_word(1'b1, i / 4, i % 4, d);
         check((i < 4 || i >= 40) ? "R6" : "R7", d, inv_w[i], $sformatf("decryption word %0d", i));
      end
   endtask

   // ---------- scenarios ----------
   task automatic t_reset();
      check("R1", {30'd0, fwd_ready, dec_ready}, 32'd0, "flags after reset");
   endtask

   task automatic t_full_key(input logic [127:0] key, input logic [31:0] w43_known);
      int e;
      logic [31:0] d;
      build_model(key);
      load_key(key, e);
      // R4: 40 edges after column 3 (44 cycles incl. loading)
      check("R4", 32'(e), 32'd40, "edges to fwd_ready");
      check("R5", {31'd0, dec_ready}, 32'd0, "dec_ready low after forward pass");
      check("R3", exp_w[43], w43_known, "model round-10 word 3");
      check_fwd_region("R3");
      read_word(1'b0, 10, 3, d);
      check("R8", d, w43_known, "read round 10 column 3");
      run_inv(e);
      check("R5", 32'(e), 32'd48, "edges to dec_ready");
      check("R5", {31'd0, fwd_ready}, 32'd1, "fwd_ready held during decryption");
      check_inv_region();
      // R11: forward region untouched
      check_fwd_region("R11");
   endtask

   task automatic t_early_request();
      write_col(0, 32'h0badf00d);
      check("R9", {30'd0, fwd_ready, dec_ready}, 32'd0, "flags after partial load");
      @(negedge clk);
      inv_req = 1'b1;
      @(posedge clk);
      @(negedge clk);
      inv_req = 1'b0;
      repeat (60) @(posedge clk);
      @(negedge clk);
      check("R10", {30'd0, fwd_ready, dec_ready}, 32'd0, "flags after early inv_req");
   endtask

   task automatic t_known_first_round();
      check("R3", exp_w[4], 32'ha0fafe17, "model round-1 word 0");
   endtask

   initial begin
      #(CLK_P * 100000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_full_key(128'h2b7e151628aed2a6abf7158809cf4f3c, 32'hb6630ca6);
      t_known_first_round();
      t_early_request();
      t_full_key(128'h000102030405060708090a0b0c0d0e0f, 32'h4d2b30c5);
      build_model(128'hffffffffffffffffffffffffffffffff);
      t_full_key(128'hffffffffffffffffffffffffffffffff, exp_w[43]);
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule